// File: doc/BRIEF.md
# Comparator Edge-Interrupt Control and Status Register

This block is the digital side of an on-chip voltage comparator. It holds one 8-bit memory-mapped register. A simple CPU bus can reach that register at two addresses. One is a data-space address. The other is an I/O-space alias that lies 0x20 below it. The raw comparator output enters from the analog block and passes through a two-stage synchronizer. The block then watches it for the edge picked by a two-bit mode field. When that edge occurs, the block latches an interrupt flag, and it raises an interrupt request if the interrupt enable bit is set.

The register also carries three control levels that leave the block: a comparator power-down, a bandgap-reference select and a capture-timer enable. While the capture enable is set, the synchronized comparator level is also forwarded to the capture timer as its trigger.

The edge detector forms its previous sample under the mode that was in force one cycle earlier. Rewriting the mode field can therefore raise the flag even when the comparator level has not changed. Software must clear the interrupt enable before it changes the mode.

Top module: `cmp_irq_csr`

## Requirements
- R1: After synchronous reset every register bit is 0. A read returns 0x00 while the comparator input is low, and irq_req is 0.
- R2: The register is selected when bus_io=0 and bus_addr=0x50, or when bus_io=1 and bus_addr=0x30. Any other access writes nothing and reads back 0x00.
- R3: Bit layout: bit 7 power-down (driven on cmp_off), bit 6 bandgap select (bg_sel), bit 5 comparator level, bit 4 interrupt flag, bit 3 interrupt enable, bit 2 capture enable (cap_en), bits 1:0 mode. A write takes effect at the clock edge that samples it. bus_rdata holds the value from before that edge, registered one cycle after bus_re.
- R4: Bit 5 reads the comparator input delayed by two clock edges. Writes to bit 5 are ignored.
- R5: Mode 00 sets the flag on any change of the synchronized level. Mode 10 sets it on a 1-to-0 change. Mode 11 sets it on a 0-to-1 change. The flag is set at the edge after the synchronized level changes, which is three edges after the raw input changes.
- R6: Mode 01 is reserved and never sets the flag.
- R7: In modes 10 and 11 the flag is set when the selected level is 1 now and was 0 one cycle earlier. The selected level is the synchronized level, inverted when the mode is 10. The earlier value was formed under the mode in force at that time. A mode rewrite with no comparator change can therefore set the flag.
- R8: The flag clears when a selected write has bit 4 = 1, or when irq_ack is 1. A selected write with bit 4 = 0 leaves the flag unchanged.
- R9: If a set event and a clear fall in the same cycle, the flag ends up set.
- R10: irq_req equals flag AND interrupt enable.
- R11: While bit 7 is 1, no event sets the flag. Clearing bit 7 does not by itself set the flag.
- R12: cap_trig equals cap_en AND the synchronized comparator level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_io | input | 1 | 1 = I/O-space access, 0 = data-space access |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| cmp_raw | input | 1 | Asynchronous comparator output |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_req | output | 1 | Interrupt request |
| cmp_off | output | 1 | Comparator power-down |
| bg_sel | output | 1 | Bandgap reference select |
| cap_en | output | 1 | Capture-timer enable |
| cap_trig | output | 1 | Capture trigger (synchronized level, gated) |

## Verification
Two events can land in the same cycle: a detected comparator edge, and a flag clear from a bus write or from irq_ack. The directed sequence waits until the synchronized falling edge is pending. It then issues a write with bit 4 set in that exact cycle and expects the flag to remain set. The random phase moves the comparator input, writes random bytes at hit and miss addresses, and pulses irq_ack. In those runs the set and clear coincidences happen many times, and a cycle-accurate bench model judges every outcome, including the spurious set caused by a mode rewrite.

// File: rtl/cmp_csr_pkg.sv
package cmp_csr_pkg;
  localparam int REG_W = 8;

  // bit positions of the control/status byte
  localparam int B_OFF  = 7;
  localparam int B_BG   = 6;
  localparam int B_LVL  = 5;
  localparam int B_FLAG = 4;
  localparam int B_IE   = 3;
  localparam int B_CAP  = 2;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       off;
    logic       bg;
    logic       ie;
    logic       cap;
    edge_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       off,
  input  edge_mode_e mode,
  output logic       evt
);
  logic prev_lvl;
  logic prev_sel;
  logic sel;

  // level seen by the edge modes: inverted for falling detection
  assign sel = lvl ^ (mode == MODE_FALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      prev_sel <= 1'b0;
    end else begin
      prev_lvl <= lvl;
      prev_sel <= sel;
    end
  end

  always_comb begin
    evt = 1'b0;
    if (!off) begin
      unique case (mode)
        MODE_ANY:            evt = lvl ^ prev_lvl;
        MODE_FALL, MODE_RISE: evt = sel & ~prev_sel;
        default:             evt = 1'b0;
      endcase
    end
  end

  a_r6_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RSVD) |-> !evt);
  a_r11_off_no_event: assert property (@(posedge clk) disable iff (rst)
    off |-> !evt);
endmodule

// File: rtl/cmp_irq_csr.sv
module cmp_irq_csr
  import cmp_csr_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h50,
  parameter int                IO_GAP   = 32,
  parameter int                SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_io,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              cmp_raw,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic              cmp_off,
  output logic              bg_sel,
  output logic              cap_en,
  output logic              cap_trig
);
  localparam logic [ADDR_W-1:0] IO_OFS = ADDR_W'(int'(DATA_OFS) - IO_GAP);

  ctrl_t ctl_q;
  logic  flag_q;
  logic  lvl_s;
  logic  evt;
  logic  hit;
  logic  wr_hit;
  logic  clr;
  logic [REG_W-1:0] rd_val;

  cmp_sync #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(cmp_raw),
    .q_sync (lvl_s)
  );

  cmp_edge_det u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (lvl_s),
    .off (ctl_q.off),
    .mode(ctl_q.mode),
    .evt (evt)
  );

  assign hit    = bus_io ? (bus_addr == IO_OFS) : (bus_addr == DATA_OFS);
  assign wr_hit = bus_we & hit;
  assign clr    = (wr_hit & bus_wdata[B_FLAG]) | irq_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_hit) begin
      ctl_q.off  <= bus_wdata[B_OFF];
      ctl_q.bg   <= bus_wdata[B_BG];
      ctl_q.ie   <= bus_wdata[B_IE];
      ctl_q.cap  <= bus_wdata[B_CAP];
      ctl_q.mode <= edge_mode_e'(bus_wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  always_comb begin
    rd_val         = '0;
    rd_val[B_OFF]  = ctl_q.off;
    rd_val[B_BG]   = ctl_q.bg;
    rd_val[B_LVL]  = lvl_s;
    rd_val[B_FLAG] = flag_q;
    rd_val[B_IE]   = ctl_q.ie;
    rd_val[B_CAP]  = ctl_q.cap;
    rd_val[1:0]    = ctl_q.mode;
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_re && hit)   bus_rdata <= rd_val;
    else                      bus_rdata <= '0;
  end

  assign irq_req  = flag_q & ctl_q.ie;
  assign cmp_off  = ctl_q.off;
  assign bg_sel   = ctl_q.bg;
  assign cap_en   = ctl_q.cap;
  assign cap_trig = ctl_q.cap & lvl_s;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q);
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt) |=> !flag_q);
  a_r11_flag_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    ctl_q.off |=> !$rose(flag_q));
  a_r12_trigger_gated: assert property (@(posedge clk) disable iff (rst)
    cap_trig |-> cap_en);
  a_r10_no_req_without_flag: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (flag_q && cap_en == ctl_q.cap));
endmodule

// File: tb/tb_cmp_irq_csr.sv
module tb_cmp_irq_csr;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_io = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cmp_raw = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_req, cmp_off, bg_sel, cap_en, cap_trig;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cmp_irq_csr dut (
    .clk(clk), .rst(rst), .bus_io(bus_io), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_raw(cmp_raw), .irq_ack(irq_ack),
    .irq_req(irq_req), .cmp_off(cmp_off), .bg_sel(bg_sel),
    .cap_en(cap_en), .cap_trig(cap_trig)
  );

  // ---------------- reference model, built from the requirements
  logic [7:0] m_reg;    // bit 5 unused here
  logic       m_a, m_s, m_ps, m_psel;
  logic [7:0] m_rd;

  function automatic bit sel_hit(input logic io, input logic [7:0] a);
    return io ? (a == 8'h30) : (a == 8'h50);
  endfunction

  function automatic logic picked(input logic lvl, input logic [1:0] md);
    return (md == 2'b10) ? ~lvl : lvl;
  endfunction

  function automatic logic fires(input logic [7:0] r, input logic s,
                                 input logic ps, input logic psel);
    if (r[7]) return 1'b0;
    case (r[1:0])
      2'b00:   return s != ps;
      2'b10,
      2'b11:   return picked(s, r[1:0]) && !psel;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] view(input logic [7:0] r, input logic s);
    logic [7:0] v;
    v = r;
    v[5] = s;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= 8'h00; m_a <= 1'b0; m_s <= 1'b0; m_ps <= 1'b0;
      m_psel <= 1'b0; m_rd <= 8'h00;
    end else begin
      logic hitc, setv, clrv;
      logic [7:0] nr;
      hitc = sel_hit(bus_io, bus_addr);
      setv = fires(m_reg, m_s, m_ps, m_psel);
      clrv = irq_ack || (bus_we && hitc && bus_wdata[4]);
      nr = m_reg;
      if (bus_we && hitc) begin
        nr[7:6] = bus_wdata[7:6];
        nr[3:0] = bus_wdata[3:0];
      end
      nr[4] = setv ? 1'b1 : (clrv ? 1'b0 : m_reg[4]);
      nr[5] = 1'b0;
      m_rd   <= (bus_re && hitc) ? view(m_reg, m_s) : 8'h00;
      m_psel <= picked(m_s, m_reg[1:0]);
      m_ps   <= m_s;
      m_s    <= m_a;
      m_a    <= cmp_raw;
      m_reg  <= nr;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 read data",        bus_rdata, m_rd);
      chk("R10 irq_req",         {7'd0, irq_req},  {7'd0, m_reg[4] & m_reg[3]});
      chk("R12 cap_trig",        {7'd0, cap_trig}, {7'd0, m_reg[2] & m_s});
      chk("R3 control outputs",  {5'd0, cmp_off, bg_sel, cap_en},
                                 {5'd0, m_reg[7], m_reg[6], m_reg[2]});
    end
  end

  // ---------------- stimulus helpers
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic io, input logic [7:0] a, input logic [7:0] d);
    bus_io = io; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic io, input logic [7:0] a,
                        input logic [7:0] exp, input string tag);
    bus_io = io; bus_addr = a; bus_re = 1'b1;
    step(1);
    bus_re = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst = 1'b0;
    step(1);

    rd_chk(1'b0, 8'h50, 8'h00, "R1 reset value");
    chk("R1 irq after reset", {7'd0, irq_req}, 8'h00);

    wr(1'b1, 8'h30, 8'h0F);
    rd_chk(1'b0, 8'h50, 8'h0F, "R2 io alias write, data read");
    wr(1'b0, 8'h30, 8'hFF);
    wr(1'b1, 8'h50, 8'hFF);
    rd_chk(1'b1, 8'h30, 8'h0F, "R2 miss writes ignored");
    rd_chk(1'b0, 8'h51, 8'h00, "R2 miss read zero");

    cmp_raw = 1'b1; step(3);
    rd_chk(1'b0, 8'h50, 8'h3F, "R5 rising sets flag, R4 level");
    chk("R10 irq raised", {7'd0, irq_req}, 8'h01);
    chk("R12 trigger follows level", {7'd0, cap_trig}, 8'h01);

    wr(1'b0, 8'h50, 8'h0F);
    rd_chk(1'b0, 8'h50, 8'h3F, "R8 write 0 keeps flag");
    wr(1'b0, 8'h50, 8'h1F);
    rd_chk(1'b0, 8'h50, 8'h2F, "R8 write 1 clears flag");

    wr(1'b0, 8'h50, 8'h0D);
    cmp_raw = 1'b0; step(3);
    cmp_raw = 1'b1; step(3);
    rd_chk(1'b0, 8'h50, 8'h2D, "R6 reserved mode silent");

    wr(1'b0, 8'h50, 8'h0E);
    wr(1'b0, 8'h50, 8'h0F);
    step(1);
    rd_chk(1'b0, 8'h50, 8'h3F, "R7 mode rewrite spurious set");
    wr(1'b0, 8'h50, 8'h1E);

    cmp_raw = 1'b0; step(2);
    wr(1'b0, 8'h50, 8'h1E);
    rd_chk(1'b0, 8'h50, 8'h1E, "R9 set wins over clear");
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    rd_chk(1'b0, 8'h50, 8'h0E, "R8 ack clears flag");

    wr(1'b0, 8'h50, 8'h8E);
    chk("R3 power-down output", {7'd0, cmp_off}, 8'h01);
    cmp_raw = 1'b1; step(3);
    cmp_raw = 1'b0; step(3);
    rd_chk(1'b0, 8'h50, 8'h8E, "R11 no flag while off");
    wr(1'b0, 8'h50, 8'h0E);
    step(2);
    rd_chk(1'b0, 8'h50, 8'h0E, "R11 re-enable no false edge");
    cmp_raw = 1'b1; step(3);
    cmp_raw = 1'b0; step(3);
    rd_chk(1'b0, 8'h50, 8'h1E, "R5 falling sets flag");

    wr(1'b0, 8'h50, 8'h2E);
    rd_chk(1'b0, 8'h50, 8'h1E, "R4 bit 5 read-only");

    wr(1'b0, 8'h50, 8'h10);
    cmp_raw = 1'b1; step(3);
    rd_chk(1'b0, 8'h50, 8'h30, "R5 toggle mode sets flag");
    chk("R10 no irq when disabled", {7'd0, irq_req}, 8'h00);
    chk("R12 no trigger when capture off", {7'd0, cap_trig}, 8'h00);

    // random phase, checked each cycle by the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 15) cmp_raw = ~cmp_raw;
      irq_ack = ($urandom_range(0, 19) == 0);
      bus_we  = ($urandom_range(0, 5) == 0);
      bus_re  = ($urandom_range(0, 2) == 0);
      bus_wdata = 8'($urandom);
      case ($urandom_range(0, 4))
        0: begin bus_io = 1'b0; bus_addr = 8'h50; end
        1: begin bus_io = 1'b1; bus_addr = 8'h30; end
        2: begin bus_io = 1'b0; bus_addr = 8'h30; end
        3: begin bus_io = 1'b1; bus_addr = 8'h50; end
        default: begin bus_io = 1'($urandom); bus_addr = 8'($urandom); end
      endcase
      step(1);
    end
    bus_we = 1'b0; bus_re = 1'b0; irq_ack = 1'b0;
    step(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule